// File: doc/BRIEF.md
# ATA Status Wait Engine

This block waits until a selected ATA device can accept a command or a data phase. After a start request it waits briefly, then polls the alternate status register until the BUSY bit clears. The polling interval starts short and grows once enough wait time has built up, and an overall wait budget bounds the whole busy stage. If a status read returns all ones, the bus is taken to be floating, and the block writes the drive/head register again to reselect the unit before it retries.

Once BUSY has cleared, the block can run a second stage that waits for a requested set of status bits, such as ready and data request, to all read as set. It reports one of four result codes on a one-cycle completion pulse. All delays count a one-microsecond tick input, so the block runs on any clock that is faster than the tick. Command issue and data movement belong to the logic around the block.

Top module: `ata_wait_engine`

## Requirements
- R1: After reset, busy_o, done_o, reg_rd_o and reg_wr_o are 0 and result_o is 0.
- R2: When idle, start_i captures mask_i and unit_i. The first status read (reg_rd_o, alternate status) comes START_US ticks after the start cycle. A tick in the start cycle is not counted.
- R3: During the busy stage, each read whose status has bit 7 (BUSY) set and is not 0xFF is followed by a wait. The wait is FAST_US ticks while the accumulated wait is at most FAST_LIMIT_US, and SLOW_US ticks after that. The accumulated wait grows by the same amount. The next read follows the wait, and two reads are never in adjacent cycles.
- R4: A busy-stage read of 0xFF is followed in the next cycle by a write (reg_wr_o) of 0xA0 with the captured unit in bit 4. The accumulated wait then grows by SLOW_US, and SLOW_US ticks pass before the next read.
- R5: If the accumulated wait is at least BUSY_LIMIT_US when a read is due, the block finishes with result 2 (busy timeout) without reading.
- R6: With a captured mask of 0, the block finishes one cycle after the read that shows BUSY clear. The result is 0 when that status has bit 0 (ERR) clear and 1 when it is set.
- R7: With a nonzero mask, START_US ticks after the read that shows BUSY clear, the block reads again every FAST_US ticks. It finishes on the first read where every mask bit is set, with result 0 or 1 from the ERR bit of that read.
- R8: If MASK_SAMPLES mask-stage reads in a row miss the mask, the block finishes with result 3 (mask timeout) in the cycle after the last read.
- R9: start_i is ignored while busy_o is 1, including any new mask_i and unit_i values.
- R10: done_o is a one-cycle pulse that coincides with busy_o falling to 0. result_o is valid while done_o is high and holds until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| mask_i | input | 8 | Status bits required in the second stage, 0 to skip it |
| unit_i | input | 1 | Device number used for reselect |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| reg_rd_o | output | 1 | Alternate status read strobe |
| reg_rdata_i | input | 8 | Status byte, valid in the cycle reg_rd_o is high |
| reg_wr_o | output | 1 | Drive/head register write strobe |
| reg_wdata_o | output | 8 | Drive/head write value |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | Completion pulse |
| result_o | output | 2 | 0 ok, 1 error, 2 busy timeout, 3 mask timeout |

## Verification
The bound assertions check cycle-level properties on every clock. Reads are never back to back. Each reselect writes the right pattern and is followed by a quiet cycle. Completion pulses for exactly one cycle, as busy drops. Busy rises only in response to a start. Only the bench's scenarios can show how many ticks pass between reads, how the interval switches from short to long as the wait builds up, when each budget runs out, and which result code comes back. To check these, a behavioural model is stepped against the design for ready, erroring, slow, floating, never-ready and mask-starved devices, and a second start is issued in the middle of a wait.

// File: rtl/ata_wait_pkg.sv
`timescale 1ns/1ps
package ata_wait_pkg;
  localparam int unsigned BSY_BIT = 7;
  localparam int unsigned ERR_BIT = 0;
  localparam int unsigned DEV_BIT = 4;
  localparam logic [7:0]  DRV_BASE = 8'hA0;
  localparam logic [7:0]  FLOAT_VAL = 8'hFF;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_ERR     = 2'd1,
    RES_BUSY_TO = 2'd2,
    RES_MASK_TO = 2'd3
  } wait_res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETTLE,
    S_CHECK,
    S_RESEL,
    S_BWAIT,
    S_MSETTLE,
    S_MREAD,
    S_MWAIT
  } wait_state_e;
endpackage

// File: rtl/ata_wait_timer.sv
`timescale 1ns/1ps
module ata_wait_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  // last counted tick of the interval
  assign expire_o = tick_i && !load_i && (cnt_q == W'(1));
endmodule

// File: rtl/ata_wait_budget.sv
`timescale 1ns/1ps
module ata_wait_budget #(
  parameter int unsigned FAST_US       = 10,
  parameter int unsigned SLOW_US       = 1000,
  parameter int unsigned FAST_LIMIT_US = 1000,
  parameter int unsigned BUSY_LIMIT_US = 1000000,
  localparam int unsigned AW = $clog2(BUSY_LIMIT_US + SLOW_US + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic add_i,
  input  logic slow_i,
  output logic past_fast_o,
  output logic exhausted_o
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] step;

  assign step = slow_i ? AW'(SLOW_US) : AW'(FAST_US);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + step;
  end

  assign past_fast_o = acc_q > AW'(FAST_LIMIT_US);
  assign exhausted_o = acc_q >= AW'(BUSY_LIMIT_US);
endmodule

// File: rtl/ata_status_eval.sv
`timescale 1ns/1ps
module ata_status_eval
  import ata_wait_pkg::*;
#(
  parameter int unsigned SW = 8
) (
  input  logic [SW-1:0] status_i,
  input  logic [SW-1:0] mask_i,
  output logic          floating_o,
  output logic          bsy_o,
  output logic          err_o,
  output logic          mask_met_o
);
  logic [SW-1:0] hit;

  for (genvar i = 0; i < SW; i++) begin : g_hit
    assign hit[i] = !mask_i[i] || status_i[i];
  end

  assign floating_o = &status_i;
  assign bsy_o      = status_i[BSY_BIT];
  assign err_o      = status_i[ERR_BIT];
  assign mask_met_o = &hit;
endmodule

// File: rtl/ata_wait_ctrl.sv
`timescale 1ns/1ps
module ata_wait_ctrl
  import ata_wait_pkg::*;
#(
  parameter int unsigned START_US     = 1,
  parameter int unsigned FAST_US      = 10,
  parameter int unsigned SLOW_US      = 1000,
  parameter int unsigned MASK_SAMPLES = 5000,
  parameter int unsigned TW           = 10,
  localparam int unsigned CW = $clog2(MASK_SAMPLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    mask_i,
  input  logic          unit_i,
  input  logic          expire_i,
  input  logic          floating_i,
  input  logic          bsy_i,
  input  logic          err_i,
  input  logic          mask_met_i,
  input  logic          past_fast_i,
  input  logic          exhausted_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          acc_clear_o,
  output logic          acc_add_o,
  output logic          acc_slow_o,
  output logic [7:0]    mask_q_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [7:0]    wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  wait_state_e state_q, state_d;
  logic [7:0]    mask_q;
  logic          unit_q;
  logic [CW-1:0] scnt_q;
  logic          scnt_inc;
  logic          fin;
  wait_res_e     fin_code;
  logic          done_q;
  wait_res_e     res_q;

  always_comb begin
    state_d     = state_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    acc_clear_o = 1'b0;
    acc_add_o   = 1'b0;
    acc_slow_o  = 1'b0;
    rd_o        = 1'b0;
    wr_o        = 1'b0;
    scnt_inc    = 1'b0;
    fin         = 1'b0;
    fin_code    = RES_OK;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d     = S_SETTLE;
          tmr_load_o  = 1'b1;
          tmr_val_o   = TW'(START_US);
          acc_clear_o = 1'b1;
        end
      end
      S_SETTLE: if (expire_i) state_d = S_CHECK;
      S_CHECK: begin
        if (exhausted_i) begin
          fin      = 1'b1;
          fin_code = RES_BUSY_TO;
        end else begin
          rd_o = 1'b1;
          if (floating_i) begin
            acc_add_o  = 1'b1;
            acc_slow_o = 1'b1;
            state_d    = S_RESEL;
          end else if (!bsy_i) begin
            if (mask_q == '0) begin
              fin      = 1'b1;
              fin_code = err_i ? RES_ERR : RES_OK;
            end else begin
              tmr_load_o = 1'b1;
              tmr_val_o  = TW'(START_US);
              state_d    = S_MSETTLE;
            end
          end else begin
            acc_add_o  = 1'b1;
            acc_slow_o = past_fast_i;
            tmr_load_o = 1'b1;
            tmr_val_o  = past_fast_i ? TW'(SLOW_US) : TW'(FAST_US);
            state_d    = S_BWAIT;
          end
        end
      end
      S_RESEL: begin
        wr_o       = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(SLOW_US);
        state_d    = S_BWAIT;
      end
      S_BWAIT:   if (expire_i) state_d = S_CHECK;
      S_MSETTLE: if (expire_i) state_d = S_MREAD;
      S_MREAD: begin
        rd_o = 1'b1;
        if (mask_met_i) begin
          fin      = 1'b1;
          fin_code = err_i ? RES_ERR : RES_OK;
        end else if (scnt_q == CW'(MASK_SAMPLES - 1)) begin
          fin      = 1'b1;
          fin_code = RES_MASK_TO;
        end else begin
          scnt_inc   = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(FAST_US);
          state_d    = S_MWAIT;
        end
      end
      S_MWAIT: if (expire_i) state_d = S_MREAD;
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
      unit_q  <= 1'b0;
      scnt_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) res_q <= fin_code;
      if (state_q == S_IDLE && start_i) begin
        mask_q <= mask_i;
        unit_q <= unit_i;
        scnt_q <= '0;
      end else if (scnt_inc) begin
        scnt_q <= scnt_q + CW'(1);
      end
    end
  end

  assign mask_q_o = mask_q;
  assign wdata_o  = DRV_BASE | (8'(unit_q) << DEV_BIT);
  assign busy_o   = state_q != S_IDLE;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/ata_wait_engine.sv
`timescale 1ns/1ps
module ata_wait_engine #(
  parameter int unsigned START_US      = 1,
  parameter int unsigned FAST_US       = 10,
  parameter int unsigned SLOW_US       = 1000,
  parameter int unsigned FAST_LIMIT_US = 1000,
  parameter int unsigned BUSY_LIMIT_US = 1000000,
  parameter int unsigned MASK_SAMPLES  = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  input  logic       unit_i,
  input  logic       us_tick_i,
  output logic       reg_rd_o,
  input  logic [7:0] reg_rdata_i,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);
  localparam int unsigned T_A  = (SLOW_US > FAST_US) ? SLOW_US : FAST_US;
  localparam int unsigned TMAX = (T_A > START_US) ? T_A : START_US;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  logic          tmr_load, expire;
  logic [TW-1:0] tmr_val;
  logic          acc_clear, acc_add, acc_slow, past_fast, exhausted;
  logic          floating, bsy, err, mask_met;
  logic [7:0]    mask_q;

  ata_wait_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .load_val_i(tmr_val), .tick_i(us_tick_i), .expire_o(expire)
  );

  ata_wait_budget #(
    .FAST_US(FAST_US), .SLOW_US(SLOW_US),
    .FAST_LIMIT_US(FAST_LIMIT_US), .BUSY_LIMIT_US(BUSY_LIMIT_US)
  ) u_budget (
    .clk_i, .rst_ni,
    .clear_i(acc_clear), .add_i(acc_add), .slow_i(acc_slow),
    .past_fast_o(past_fast), .exhausted_o(exhausted)
  );

  ata_status_eval #(.SW(8)) u_eval (
    .status_i(reg_rdata_i), .mask_i(mask_q),
    .floating_o(floating), .bsy_o(bsy), .err_o(err), .mask_met_o(mask_met)
  );

  ata_wait_ctrl #(
    .START_US(START_US), .FAST_US(FAST_US), .SLOW_US(SLOW_US),
    .MASK_SAMPLES(MASK_SAMPLES), .TW(TW)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .mask_i, .unit_i,
    .expire_i(expire), .floating_i(floating), .bsy_i(bsy), .err_i(err),
    .mask_met_i(mask_met), .past_fast_i(past_fast), .exhausted_i(exhausted),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .acc_clear_o(acc_clear), .acc_add_o(acc_add), .acc_slow_o(acc_slow),
    .mask_q_o(mask_q),
    .rd_o(reg_rd_o), .wr_o(reg_wr_o), .wdata_o(reg_wdata_o),
    .busy_o, .done_o, .result_o
  );
endmodule

// File: rtl/ata_wait_chk.sv
`timescale 1ns/1ps
module ata_wait_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rd_o,
  input logic       wr_o,
  input logic [7:0] wdata_o,
  input logic       busy_o,
  input logic       done_o
);
  // R2
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> busy_o);
  // R3
  rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  // R4
  resel_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ((wdata_o & 8'hEF) == 8'hA0) && !rd_o);
  // R4
  resel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !rd_o && !wr_o && busy_o);
  // R9
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

bind ata_wait_engine ata_wait_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .rd_o(reg_rd_o), .wr_o(reg_wr_o), .wdata_o(reg_wdata_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_ata_wait_engine.sv
`timescale 1ns/1ps
module sim_ata_wait_engine;
  localparam int START_US = 1, FAST_US = 2, SLOW_US = 5, FAST_LIMIT_US = 6;
  localparam int BUSY_LIMIT_US = 40, MASK_SAMPLES = 4, TDIV = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, unit_i = 1'b0, us_tick_i = 1'b0;
  logic [7:0] mask_i = '0, rdata_r = 8'h00;
  logic reg_rd_o, reg_wr_o, busy_o, done_o;
  logic [7:0] reg_wdata_o;
  logic [1:0] result_o;

  ata_wait_engine #(
    .START_US(START_US), .FAST_US(FAST_US), .SLOW_US(SLOW_US),
    .FAST_LIMIT_US(FAST_LIMIT_US), .BUSY_LIMIT_US(BUSY_LIMIT_US),
    .MASK_SAMPLES(MASK_SAMPLES)
  ) u0 (
    .clk_i, .rst_ni, .start_i, .mask_i, .unit_i, .us_tick_i,
    .reg_rd_o, .reg_rdata_i(rdata_r), .reg_wr_o, .reg_wdata_o,
    .busy_o, .done_o, .result_o
  );

  always #2 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] dev_q[$];
  bit pop_pend = 1'b0;
  int tick_ph = 0;
  bit tk;
  logic [7:0] sv;
  logic [7:0] mask_cur;
  bit unit_cur;
  bit poke_pending = 1'b0;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of the reference model: compare, then drive this cycle's inputs
  task automatic step(string req, bit e_busy, bit e_rd, bit e_wr, bit e_done,
                      logic [1:0] e_res, bit go);
    @(negedge clk_i);
    if (pop_pend && dev_q.size() > 1) dev_q.delete(0);
    pop_pend = e_rd;
    rdata_r  = dev_q[0];
    sv       = dev_q[0];
    chk(req, "busy", 8'(busy_o), 8'(e_busy));
    chk(req, "rd", 8'(reg_rd_o), 8'(e_rd));
    chk(req, "wr", 8'(reg_wr_o), 8'(e_wr));
    chk(req, "done", 8'(done_o), 8'(e_done));
    if (e_wr) chk(req, "wdata", reg_wdata_o, 8'hA0 | (8'(unit_cur) << 4));
    if (e_done) chk(req, "result", 8'(result_o), 8'(e_res));
    if (e_busy && poke_pending) begin
      start_i = 1'b1;
      mask_i  = 8'hFF;
      unit_i  = ~unit_cur;
      poke_pending = 1'b0;
    end else begin
      start_i = go;
    end
    tk = (tick_ph == 0);
    us_tick_i = tk;
    tick_ph = (tick_ph + 1) % TDIV;
  endtask

  task automatic wait_ticks(int n, string req);
    int cnt = 0;
    while (cnt < n) begin
      step(req, 1, 0, 0, 0, 2'd0, 0);
      if (tk) cnt++;
    end
  endtask

  task automatic load_dev(logic [7:0] vals[$]);
    dev_q = vals;
    pop_pend = 1'b0;
  endtask

  task automatic run(logic [7:0] m, bit u, bit poke);
    int acc = 0;
    logic [7:0] st;
    mask_cur = m; unit_cur = u; mask_i = m; unit_i = u;
    step("R2", 0, 0, 0, 0, 2'd0, 1);
    poke_pending = poke;
    wait_ticks(START_US, "R2");
    forever begin
      if (acc >= BUSY_LIMIT_US) begin
        step("R5", 1, 0, 0, 0, 2'd0, 0);
        step("R5", 0, 0, 0, 1, 2'd2, 0);
        step("R10", 0, 0, 0, 0, 2'd0, 0);
        return;
      end
      step("R3", 1, 1, 0, 0, 2'd0, 0);
      st = sv;
      if (st == 8'hFF) begin
        acc += SLOW_US;
        step("R4", 1, 0, 1, 0, 2'd0, 0);
        wait_ticks(SLOW_US, "R4");
        continue;
      end
      if (!st[7]) break;
      if (acc > FAST_LIMIT_US) begin
        acc += SLOW_US;
        wait_ticks(SLOW_US, "R3");
      end else begin
        acc += FAST_US;
        wait_ticks(FAST_US, "R3");
      end
    end
    if (m == 8'h00) begin
      step("R6", 0, 0, 0, 1, {1'b0, st[0]}, 0);
      step("R10", 0, 0, 0, 0, 2'd0, 0);
      return;
    end
    wait_ticks(START_US, "R7");
    for (int k = 0; k < MASK_SAMPLES; k++) begin
      step("R7", 1, 1, 0, 0, 2'd0, 0);
      st = sv;
      if ((st & m) == m) begin
        step("R7", 0, 0, 0, 1, {1'b0, st[0]}, 0);
        step("R10", 0, 0, 0, 0, 2'd0, 0);
        return;
      end
      if (k == MASK_SAMPLES - 1) begin
        step("R8", 0, 0, 0, 1, 2'd3, 0);
        step("R10", 0, 0, 0, 0, 2'd0, 0);
        return;
      end
      wait_ticks(FAST_US, "R7");
    end
  endtask

  initial begin
    load_dev('{8'h50});
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1", 0, 0, 0, 0, 2'd0, 0);
    chk("R1", "result", 8'(result_o), 8'h00);
    step("R1", 0, 0, 0, 0, 2'd0, 0);

    // ready at once, no mask: ok
    load_dev('{8'h50});
    run(8'h00, 1'b0, 1'b0);
    // busy past the fast window, then error: R3 R6
    load_dev('{8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h51});
    run(8'h00, 1'b0, 1'b0);
    // floating twice then ready, unit 1: R4
    load_dev('{8'hFF, 8'hFF, 8'h50});
    run(8'h00, 1'b1, 1'b0);
    // never leaves busy: R5
    load_dev('{8'h80});
    run(8'h00, 1'b0, 1'b0);
    // floats forever: reselect until budget gone, R4 R5
    load_dev('{8'hFF});
    run(8'h00, 1'b1, 1'b0);
    // mask stage succeeds on third sample: R7
    load_dev('{8'h80, 8'h50, 8'h40, 8'h10, 8'h58});
    run(8'h48, 1'b0, 1'b0);
    // mask met with ERR set: R7
    load_dev('{8'h59});
    run(8'h08, 1'b1, 1'b0);
    // mask never met: R8
    load_dev('{8'h50});
    run(8'h08, 1'b0, 1'b0);
    // second start during wait ignored: R9
    load_dev('{8'h80, 8'h80, 8'h50});
    run(8'h00, 1'b0, 1'b1);
    chk("R9", "done", 8'(done_o), 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule